// File: doc/BRIEF.md
# Receiver Error Interrupt Controller

This block gathers status events from a digital audio receiver and turns them into two interrupt lines, each filtered by its own mask. Level events (lock loss, validity, compressed-stream detection, audio detection) are sampled each clock. Change events (sample-rate change, channel-status change, subcode change) are pulses that set sticky bits. These sticky bits clear when the status word is read. Lock loss and subframe errors are stretched by a hold time counted in frame ticks, so a brief error still produces an interrupt of useful length.

The block also sits in the recovered audio path. A subframe flagged as corrupt is replaced by the last clean subframe. While lock is lost, the output is forced to zero. Mask and hold settings are captured through a single write strobe and have defined reset values.

Top module: `rxirq_ctrl`

## Requirements
- R1: After reset, `irq0`, `irq1`, `stat_o` and `sf_out` are zero. Both mask registers reset to 8'h80, so only the subcode-change bit is masked. The hold select resets to 1.
- R2: While not unlocked, `irqN` equals the OR over bits of `stat_o & ~maskN`. A mask bit of 1 removes that status bit from that line. The `stat_o` layout is: bit0 unlock (held), bit1 subframe error (held), bit2 validity, bit3 rate change, bit4 compressed stream, bit5 audio detect, bit6 channel-status change, bit7 subcode change.
- R3: A pulse on `ev_fs_chg`, `ev_cs_chg` or `ev_q_chg` sets its sticky bit at the next edge. The bit stays 1 until a cycle with `stat_rd` high, and is 0 after that edge.
- R4: If a change pulse and `stat_rd` fall in the same cycle, the sticky bit is 1 after that edge.
- R5: Bits 0 and 1 rise at the edge that samples their error. They stay high until N frame ticks have been sampled with no error, and fall at the edge of the Nth tick. N is 512 << hold select, giving 512, 1024, 2048 or 4096.
- R6: A new error while a hold is running restarts the full N-tick count.
- R7: A subframe strobe with `sf_err` low loads `sf_data` into `sf_out`. With `sf_err` high and `ev_unlock` low, `sf_out` takes the last clean subframe.
- R8: A subframe strobe while `ev_unlock` is high makes `sf_out` zero. The stored last clean subframe is kept.
- R9: In the cycle after `ev_unlock` is sampled high, `irq0` is 1 and `irq1` equals bit4 OR bit5, regardless of the masks.
- R10: Bits 2, 4 and 5 of `stat_o` show `ev_valid`, `ev_nonpcm` and `ev_audio` as sampled at the previous edge.
- R11: With `cfg_we` high, `cfg_mask0`, `cfg_mask1` and `cfg_hold` take effect from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One pulse per audio frame |
| cfg_we | input | 1 | Capture mask and hold settings |
| cfg_mask0 | input | 8 | Mask for `irq0` |
| cfg_mask1 | input | 8 | Mask for `irq1` |
| cfg_hold | input | 2 | Hold time select |
| ev_unlock | input | 1 | Receiver lock lost (level) |
| ev_valid | input | 1 | Validity flag (level) |
| ev_nonpcm | input | 1 | Compressed stream detected (level) |
| ev_audio | input | 1 | Audio content detected (level) |
| ev_fs_chg | input | 1 | Sample-rate change pulse |
| ev_cs_chg | input | 1 | Channel-status change pulse |
| ev_q_chg | input | 1 | Subcode change pulse |
| stat_rd | input | 1 | Status read strobe, clears sticky bits |
| sf_strobe | input | 1 | Subframe data present |
| sf_err | input | 1 | Subframe has parity, biphase or length error |
| sf_data | input | 24 | Received subframe sample |
| stat_o | output | 8 | Status word |
| irq0 | output | 1 | First interrupt line |
| irq1 | output | 1 | Second interrupt line |
| sf_out | output | 24 | Audio sample after substitution |

## Verification
Most faults show up at the ports within one clock, because every status bit reaches `stat_o` and both interrupt lines one register after its input.

A hold counter that is loaded or decremented wrongly is different. It shows nothing until its count ends, so the bench samples bit 1 exactly one tick before the expected release and again at the release. This catches an off-by-one or a missed reload.

A last-clean-sample register that is corrupted stays hidden until the next errored subframe. For that reason, an errored subframe is sent right after a lock loss.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
    localparam int unsigned NSTAT = 8;

    localparam int unsigned B_UNL  = 0;
    localparam int unsigned B_SFE  = 1;
    localparam int unsigned B_VAL  = 2;
    localparam int unsigned B_FS   = 3;
    localparam int unsigned B_NPCM = 4;
    localparam int unsigned B_AUD  = 5;
    localparam int unsigned B_CS   = 6;
    localparam int unsigned B_Q    = 7;

    typedef struct packed {
        logic [NSTAT-1:0] mask0;
        logic [NSTAT-1:0] mask1;
        logic [1:0]       hold;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mask0: 8'h80, mask1: 8'h80, hold: 2'd1};

    function automatic int unsigned hold_len(input logic [1:0] sel, input int unsigned base);
        return base << sel;
    endfunction
endpackage

// File: rtl/rxirq_hold.sv
module rxirq_hold #(
    parameter int unsigned HOLD_BASE = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       err,
    input  logic [1:0] sel,
    output logic       held
);
    localparam int unsigned MAXN = HOLD_BASE * 8;
    localparam int unsigned CW   = $clog2(MAXN) + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (err)
            cnt <= CW'(rxirq_pkg::hold_len(sel, HOLD_BASE));
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign held = (cnt != '0);
endmodule

// File: rtl/rxirq_subst.sv
module rxirq_subst #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic         bad,
    input  logic         unlocked,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] last_good;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_good <= '0;
            dout      <= '0;
        end else if (strobe) begin
            if (unlocked)
                dout <= '0;
            else if (bad)
                dout <= last_good;
            else begin
                dout      <= din;
                last_good <= din;
            end
        end
    end
endmodule

// File: rtl/rxirq_line.sv
module rxirq_line #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] stat,
    input  logic [N-1:0] mask,
    input  logic         ovr,
    input  logic         ovr_val,
    output logic         irq
);
    always_comb begin
        if (ovr)
            irq = ovr_val;
        else
            irq = |(stat & ~mask);
    end
endmodule

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl
    import rxirq_pkg::*;
#(
    parameter int unsigned W         = 24,
    parameter int unsigned HOLD_BASE = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             cfg_we,
    input  logic [NSTAT-1:0] cfg_mask0,
    input  logic [NSTAT-1:0] cfg_mask1,
    input  logic [1:0]       cfg_hold,
    input  logic             ev_unlock,
    input  logic             ev_valid,
    input  logic             ev_nonpcm,
    input  logic             ev_audio,
    input  logic             ev_fs_chg,
    input  logic             ev_cs_chg,
    input  logic             ev_q_chg,
    input  logic             stat_rd,
    input  logic             sf_strobe,
    input  logic             sf_err,
    input  logic [W-1:0]     sf_data,
    output logic [NSTAT-1:0] stat_o,
    output logic             irq0,
    output logic             irq1,
    output logic [W-1:0]     sf_out
);
    localparam int unsigned NSTICKY = 3;
    localparam int unsigned NHOLD   = 2;
    localparam int unsigned NLINE   = 2;

    cfg_t cfg_q;
    logic lost_q, valid_q, npcm_q, aud_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (cfg_we)
            cfg_q <= '{mask0: cfg_mask0, mask1: cfg_mask1, hold: cfg_hold};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lost_q  <= 1'b0;
            valid_q <= 1'b0;
            npcm_q  <= 1'b0;
            aud_q   <= 1'b0;
        end else begin
            lost_q  <= ev_unlock;
            valid_q <= ev_valid;
            npcm_q  <= ev_nonpcm;
            aud_q   <= ev_audio;
        end
    end

    // sticky change flags: a set pulse wins over a concurrent read clear (R4)
    logic [NSTICKY-1:0] st_set, st_q;
    assign st_set = {ev_q_chg, ev_cs_chg, ev_fs_chg};

    for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst)
                st_q[i] <= 1'b0;
            else
                st_q[i] <= st_set[i] | (st_q[i] & ~stat_rd);
        end
    end

    // error hold stretchers: index 0 lock loss, index 1 subframe error
    logic [NHOLD-1:0] h_err, h_held;
    assign h_err = {sf_strobe & sf_err, ev_unlock};

    for (genvar i = 0; i < NHOLD; i++) begin : g_hold
        rxirq_hold #(.HOLD_BASE(HOLD_BASE)) u_hold (
            .clk  (clk),
            .rst  (rst),
            .tick (frame_tick),
            .err  (h_err[i]),
            .sel  (cfg_q.hold),
            .held (h_held[i])
        );
    end

    always_comb begin
        stat_o         = '0;
        stat_o[B_UNL]  = h_held[0];
        stat_o[B_SFE]  = h_held[1];
        stat_o[B_VAL]  = valid_q;
        stat_o[B_FS]   = st_q[0];
        stat_o[B_NPCM] = npcm_q;
        stat_o[B_AUD]  = aud_q;
        stat_o[B_CS]   = st_q[1];
        stat_o[B_Q]    = st_q[2];
    end

    logic [NSTAT-1:0] l_mask [NLINE];
    logic [NLINE-1:0] l_ovr_val, l_irq;
    assign l_mask[0]    = cfg_q.mask0;
    assign l_mask[1]    = cfg_q.mask1;
    assign l_ovr_val[0] = stat_o[B_UNL] | stat_o[B_SFE];
    assign l_ovr_val[1] = stat_o[B_NPCM] | stat_o[B_AUD];

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        rxirq_line #(.N(NSTAT)) u_line (
            .stat    (stat_o),
            .mask    (l_mask[i]),
            .ovr     (lost_q),
            .ovr_val (l_ovr_val[i]),
            .irq     (l_irq[i])
        );
    end

    assign irq0 = l_irq[0];
    assign irq1 = l_irq[1];

    rxirq_subst #(.W(W)) u_subst (
        .clk      (clk),
        .rst      (rst),
        .strobe   (sf_strobe),
        .bad      (sf_err),
        .unlocked (ev_unlock),
        .din      (sf_data),
        .dout     (sf_out)
    );
endmodule

// File: rtl/rxirq_ctrl_chk.sv
module rxirq_ctrl_chk #(
    parameter int unsigned W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         ev_unlock,
    input logic         ev_valid,
    input logic         ev_q_chg,
    input logic         stat_rd,
    input logic         sf_strobe,
    input logic         sf_err,
    input logic         lost_q,
    input logic [7:0]   mask0,
    input logic [7:0]   stat_o,
    input logic         irq0,
    input logic [W-1:0] sf_out
);
    // R2
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (!lost_q && ((stat_o & ~mask0) == 8'h00)) |-> !irq0);

    // R3
    a_r3_sticky_keeps: assert property (@(posedge clk) disable iff (rst)
        (stat_o[7] && !stat_rd) |=> stat_o[7]);

    // R4
    a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
        ev_q_chg |=> stat_o[7]);

    // R5
    a_r5_error_held: assert property (@(posedge clk) disable iff (rst)
        (sf_strobe && sf_err) |=> stat_o[1]);

    // R8
    a_r8_zero_unlocked: assert property (@(posedge clk) disable iff (rst)
        (sf_strobe && ev_unlock) |=> (sf_out == '0));

    // R9
    a_r9_unlock_irq0: assert property (@(posedge clk) disable iff (rst)
        ev_unlock |=> irq0);

    // R10
    a_r10_valid_level: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> stat_o[2]);
endmodule

bind rxirq_ctrl rxirq_ctrl_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_unlock (ev_unlock),
    .ev_valid  (ev_valid),
    .ev_q_chg  (ev_q_chg),
    .stat_rd   (stat_rd),
    .sf_strobe (sf_strobe),
    .sf_err    (sf_err),
    .lost_q    (lost_q),
    .mask0     (cfg_q.mask0),
    .stat_o    (stat_o),
    .irq0      (irq0),
    .sf_out    (sf_out)
);

// File: tb/rxirq_ctrl_test.sv
`timescale 1ns/1ps
module rxirq_ctrl_test;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst;
    logic frame_tick, cfg_we;
    logic [7:0] cfg_mask0, cfg_mask1;
    logic [1:0] cfg_hold;
    logic ev_unlock, ev_valid, ev_nonpcm, ev_audio, ev_fs_chg, ev_cs_chg, ev_q_chg;
    logic stat_rd, sf_strobe, sf_err;
    logic [W-1:0] sf_data;
    logic [7:0] stat_o;
    logic irq0, irq1;
    logic [W-1:0] sf_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rxirq_ctrl #(.W(W), .HOLD_BASE(512)) uut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .cfg_we(cfg_we),
        .cfg_mask0(cfg_mask0), .cfg_mask1(cfg_mask1), .cfg_hold(cfg_hold),
        .ev_unlock(ev_unlock), .ev_valid(ev_valid), .ev_nonpcm(ev_nonpcm),
        .ev_audio(ev_audio), .ev_fs_chg(ev_fs_chg), .ev_cs_chg(ev_cs_chg),
        .ev_q_chg(ev_q_chg), .stat_rd(stat_rd), .sf_strobe(sf_strobe),
        .sf_err(sf_err), .sf_data(sf_data), .stat_o(stat_o), .irq0(irq0),
        .irq1(irq1), .sf_out(sf_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        frame_tick = 1'b1;
        repeat (n) @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic sf_send(input logic err, input logic [W-1:0] d);
        sf_strobe = 1'b1; sf_err = err; sf_data = d;
        cyc();
        sf_strobe = 1'b0; sf_err = 1'b0;
    endtask

    task automatic cfg(input logic [7:0] m0, input logic [7:0] m1, input logic [1:0] h);
        cfg_we = 1'b1; cfg_mask0 = m0; cfg_mask1 = m1; cfg_hold = h;
        cyc();
        cfg_we = 1'b0;
    endtask

    function automatic logic line_irq(input logic [7:0] st, input logic [7:0] m);
        return |(st & ~m);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [2:0] sticky;
        logic [7:0] m0, m1, st;
        logic [W-1:0] dexp;
        seed = 1234;
        void'($urandom(seed));
        rst = 1'b1; frame_tick = 0; cfg_we = 0; cfg_mask0 = 0; cfg_mask1 = 0; cfg_hold = 0;
        ev_unlock = 0; ev_valid = 0; ev_nonpcm = 0; ev_audio = 0;
        ev_fs_chg = 0; ev_cs_chg = 0; ev_q_chg = 0; stat_rd = 0;
        sf_strobe = 0; sf_err = 0; sf_data = '0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        chk("R1 stat", stat_o, 0);
        chk("R1 irq", {irq1, irq0}, 0);
        chk("R1 sf_out", sf_out, 0);

        // default masks: subcode masked, compressed-stream bit not masked
        ev_q_chg = 1; cyc(); ev_q_chg = 0;
        chk("R3 q set", stat_o[7], 1);
        chk("R1 q masked", {irq1, irq0}, 0);
        ev_nonpcm = 1; cyc(); ev_nonpcm = 0;
        chk("R1 auto unmasked", {irq1, irq0}, 2'b11);
        chk("R10 nonpcm", stat_o[4], 1);
        cyc();
        chk("R10 nonpcm low", stat_o[4], 0);
        cyc();
        chk("R3 still set", stat_o[7], 1);
        stat_rd = 1; cyc(); stat_rd = 0;
        chk("R3 cleared", stat_o[7], 0);

        // R4: event and read in same cycle
        ev_cs_chg = 1; stat_rd = 1; cyc(); ev_cs_chg = 0; stat_rd = 0;
        chk("R4 event wins", stat_o[6], 1);
        stat_rd = 1; cyc(); stat_rd = 0;
        chk("R4 later clear", stat_o[6], 0);

        // R7 substitution and default hold (1024)
        sf_send(0, 24'hABCDEF);
        chk("R7 good load", sf_out, 24'hABCDEF);
        sf_send(1, 24'h123456);
        chk("R7 repeat", sf_out, 24'hABCDEF);
        chk("R2 err irq0", irq0, 1);
        sf_send(0, 24'h111111);
        chk("R7 good again", sf_out, 24'h111111);
        ticks(1023);
        chk("R1 hold 1024 before", stat_o[1], 1);
        ticks(1);
        chk("R1 hold 1024 end", stat_o[1], 0);
        chk("R2 irq0 released", irq0, 0);

        // R11/R5/R6 with 512
        cfg(8'h00, 8'h00, 2'd0);
        ev_fs_chg = 1; cyc(); ev_fs_chg = 0;
        chk("R11 q now unmasked path", irq1, 1);
        stat_rd = 1; cyc(); stat_rd = 0;
        sf_send(1, 24'h0);
        ticks(511);
        chk("R5 before", stat_o[1], 1);
        ticks(1);
        chk("R5 end", stat_o[1], 0);
        sf_send(1, 24'h0);
        ticks(300);
        sf_send(1, 24'h0);
        ticks(511);
        chk("R6 reload before", stat_o[1], 1);
        ticks(1);
        chk("R6 reload end", stat_o[1], 0);
        cfg(8'h00, 8'h00, 2'd2);
        sf_send(1, 24'h0);
        ticks(2047);
        chk("R5 2048 before", stat_o[1], 1);
        ticks(1);
        chk("R5 2048 end", stat_o[1], 0);
        cfg(8'h00, 8'h00, 2'd0);

        // R8/R9 lock loss
        cfg(8'hFF, 8'hFF, 2'd0);
        ev_unlock = 1; ev_nonpcm = 1; sf_strobe = 1; sf_data = 24'h55AA55;
        cyc();
        sf_strobe = 0; ev_nonpcm = 0;
        chk("R8 zero", sf_out, 0);
        chk("R9 irq0", irq0, 1);
        chk("R9 irq1", irq1, 1);
        chk("R5 unlock held", stat_o[0], 1);
        cyc();
        chk("R9 irq1 follows", irq1, 0);
        chk("R9 irq0 forced", irq0, 1);
        ev_unlock = 0; cyc();
        chk("R2 masked after lock", {irq1, irq0}, 0);
        sf_send(1, 24'h777777);
        chk("R7 last good kept", sf_out, 24'h111111);
        ticks(600);
        chk("R5 drained", stat_o[1:0], 0);

        // random mix
        sticky = '0;
        dexp = sf_out;
        for (int i = 0; i < 400; i++) begin
            m0 = 8'($urandom); m1 = 8'($urandom);
            cfg_we = 1; cfg_mask0 = m0; cfg_mask1 = m1; cfg_hold = 0;
            ev_valid = 1'($urandom); ev_nonpcm = 1'($urandom); ev_audio = 1'($urandom);
            ev_fs_chg = ($urandom % 4) == 0; ev_cs_chg = ($urandom % 4) == 0;
            ev_q_chg = ($urandom % 4) == 0; stat_rd = ($urandom % 3) == 0;
            sf_strobe = 1'($urandom); sf_data = W'($urandom);
            if (sf_strobe) dexp = sf_data;
            sticky = {ev_q_chg, ev_cs_chg, ev_fs_chg} | (sticky & {3{~stat_rd}});
            st = {sticky[2], sticky[1], ev_audio, ev_nonpcm, sticky[0], ev_valid, 2'b00};
            cyc();
            chk("R10 R3 R4 stat", stat_o, st);
            chk("R2 irq0", irq0, line_irq(st, m0));
            chk("R2 irq1", irq1, line_irq(st, m1));
            chk("R7 data", sf_out, dexp);
        end
        cfg_we = 0; sf_strobe = 0; stat_rd = 0;
        ev_fs_chg = 0; ev_cs_chg = 0; ev_q_chg = 0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule